// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned integers of `WIDTH` bits over several clock cycles and returns a product of `2*WIDTH` bits. It holds the multiplicand in one register and keeps a running sum in an accumulator. A third register starts out holding the multiplier and fills with the low half of the product. Each step looks at the lowest multiplier bit. When that bit is 1, the step adds the multiplicand into the accumulator. The step then shifts the carry bit, the accumulator and the multiplier register right by one place as a single chain. Partial products are never stored.

A client drives the operands and raises `start` for one cycle while the unit is idle. `done` then rises once the last shift has completed. It stays high, with the product held on `product`, until the next accepted `start`. The parameter `STEP_MODE` selects one of two step styles:
- **Fused:** the add and the shift of each step happen in one clock.
- **Split:** the add and the shift take a clock each, and a real carry flip-flop sits between them.

Top module: `shift_add_mul`

## Requirements
- R1: While `rst_n` is low, `product` reads 0 and `done` reads 0.
- R2: For every pair of operands, the `product` shown while `done` is high equals the unsigned product `mcand * mplier` of the operands captured at the accepted start. This includes zero operands and the case where both operands are all ones.
- R3: In fused mode, `done` first reads 1 after exactly `WIDTH` rising edges following the edge that accepts `start`.
- R4: In split mode, `done` first reads 1 after exactly `2*WIDTH` rising edges following the edge that accepts `start`.
- R5: A `start` raised while a multiply is in progress is ignored. The running operation keeps its operands, its result and its latency.
- R6: Once high, `done` stays high and `product` stays constant until the next accepted `start`.
- R7: A `start` raised while idle, including in a cycle where `done` is high, is accepted on that edge. `done` reads 0 from that edge on.
- R8: `product` is the accumulator in the upper `WIDTH` bits followed by the multiplier register in the lower bits. In fused mode with `WIDTH`=4, multiplicand 12 and multiplier 11, it reads 0x65, 0x92, 0x49 and then 0x84 after step edges 1 to 4. This holds only if the carry out of each add enters the top of the accumulator on the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiply; accepted only while idle |
| mcand | input | WIDTH | Multiplicand, sampled at an accepted start |
| mplier | input | WIDTH | Multiplier, sampled at an accepted start |
| product | output | 2*WIDTH | Accumulator concatenated with the multiplier/low register |
| done | output | 1 | High from the end of the last step until the next accepted start |

## Verification
The bench runs every pair of 4-bit operands through a fused instance and a split instance at the same time. Any carry that is lost on an add shows up as a wrong product, for example 15*15 reading below 225. The bench counts the edges up to `done` in both modes, so a counter that is off by one, or a split controller that shifts on the add phase, shows up as the wrong latency. A second `start` pulse is inserted partway through a multiply; a design that reloads on it would return the product of the second operands. The bench also walks the register chain edge by edge on the 12*11 case, which catches a shift that drops the carry or feeds the wrong bit into the low register.

// File: rtl/mul_pkg.sv
package mul_pkg;

   // How one multiplier bit is processed: add and shift in one clock, or in two.
   typedef enum logic [0:0] {
      STEP_FUSED = 1'b0,
      STEP_SPLIT = 1'b1
   } step_mode_e;

endpackage

// File: rtl/mul_adder.sv
// Ripple adder: WIDTH full-adder cells chained through a carry vector.
module mul_adder #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);

   logic [WIDTH:0] carry;

   assign carry[0] = 1'b0;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      assign sum[i]     = op_a[i] ^ op_b[i] ^ carry[i];
      assign carry[i+1] = (op_a[i] & op_b[i]) | (carry[i] & (op_a[i] ^ op_b[i]));
   end

   assign cout = carry[WIDTH];

endmodule

// File: rtl/mul_ctrl.sv
// Step sequencer: counts multiplier bits, produces add/shift strobes and done.
module mul_ctrl #(
   parameter int WIDTH = 8,
   parameter bit SPLIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic do_add,
   output logic do_shift,
   output logic busy,
   output logic done
);

   localparam int CW = $clog2(WIDTH + 1);
   localparam logic [CW-1:0] CNT_INIT = CW'(WIDTH);
   localparam logic [CW-1:0] CNT_LAST = CW'(1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          done_q;

   assign load = start & ~busy_q;
   assign busy = busy_q;
   assign done = done_q;

   if (SPLIT) begin : g_split
      // phase 0 = add clock, phase 1 = shift clock
      logic phase_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      phase_q <= 1'b0;
         else if (load)   phase_q <= 1'b0;
         else if (busy_q) phase_q <= ~phase_q;
      end
      assign do_add   = busy_q & ~phase_q;
      assign do_shift = busy_q &  phase_q;
   end else begin : g_fused
      assign do_add   = busy_q;
      assign do_shift = busy_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (load) begin
         cnt_q  <= CNT_INIT;
         busy_q <= 1'b1;
         done_q <= 1'b0;
      end else if (do_shift) begin
         cnt_q <= cnt_q - CW'(1);
         if (cnt_q == CNT_LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/mul_datapath.sv
// Multiplicand register, accumulator, multiplier/low register and the add path.
module mul_datapath #(
   parameter int WIDTH = 8,
   parameter bit SPLIT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             do_add,
   input  logic             do_shift,
   input  logic [WIDTH-1:0] mcand,
   input  logic [WIDTH-1:0] mplier,
   output logic [WIDTH-1:0] acc,
   output logic [WIDTH-1:0] low
);

   logic [WIDTH-1:0] m_q;
   logic [WIDTH-1:0] a_q;
   logic [WIDTH-1:0] q_q;
   logic [WIDTH-1:0] addend;
   logic [WIDTH-1:0] sum;
   logic             cout;

   // Add the multiplicand only on an add strobe with the lowest multiplier bit set
   assign addend = (do_add & q_q[0]) ? m_q : '0;

   mul_adder #(.WIDTH(WIDTH)) u_adder (
      .op_a (a_q),
      .op_b (addend),
      .sum  (sum),
      .cout (cout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    m_q <= '0;
      else if (load) m_q <= mcand;
   end

   if (SPLIT) begin : g_split
      // Carry flip-flop holds the adder carry until the following shift clock
      logic c_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            c_q <= 1'b0;
            a_q <= '0;
            q_q <= '0;
         end else if (load) begin
            c_q <= 1'b0;
            a_q <= '0;
            q_q <= mplier;
         end else if (do_add) begin
            c_q <= cout;
            a_q <= sum;
         end else if (do_shift) begin
            c_q <= 1'b0;
            a_q <= {c_q, a_q[WIDTH-1:1]};
            q_q <= {a_q[0], q_q[WIDTH-1:1]};
         end
      end
   end else begin : g_fused
      // Carry goes straight into the top of the accumulator in the same clock
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q <= '0;
            q_q <= '0;
         end else if (load) begin
            a_q <= '0;
            q_q <= mplier;
         end else if (do_shift) begin
            a_q <= {cout, sum[WIDTH-1:1]};
            q_q <= {sum[0], q_q[WIDTH-1:1]};
         end
      end
   end

   assign acc = a_q;
   assign low = q_q;

endmodule

// File: rtl/shift_add_mul.sv
// Sequential shift-add unsigned multiplier, top level.
module shift_add_mul #(
   parameter int                  WIDTH     = 8,
   parameter mul_pkg::step_mode_e STEP_MODE = mul_pkg::STEP_FUSED
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [WIDTH-1:0]   mcand,
   input  logic [WIDTH-1:0]   mplier,
   output logic [2*WIDTH-1:0] product,
   output logic               done
);

   localparam bit SPLIT = (STEP_MODE == mul_pkg::STEP_SPLIT);
   localparam int STEPS = SPLIT ? 2 * WIDTH : WIDTH;

   if (WIDTH < 2) begin : g_width_chk
      $error("shift_add_mul: WIDTH must be at least 2");
   end

   logic             load;
   logic             do_add;
   logic             do_shift;
   logic             busy;
   logic [WIDTH-1:0] acc;
   logic [WIDTH-1:0] low;

   mul_ctrl #(.WIDTH(WIDTH), .SPLIT(SPLIT)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .load     (load),
      .do_add   (do_add),
      .do_shift (do_shift),
      .busy     (busy),
      .done     (done)
   );

   mul_datapath #(.WIDTH(WIDTH), .SPLIT(SPLIT)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .do_add   (do_add),
      .do_shift (do_shift),
      .mcand    (mcand),
      .mplier   (mplier),
      .acc      (acc),
      .low      (low)
   );

   assign product = {acc, low};

endmodule

// File: rtl/mul_checker.sv
// Protocol and result checks, bound to every shift_add_mul instance.
module mul_checker #(
   parameter int WIDTH = 8,
   parameter int STEPS = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [WIDTH-1:0]   mcand,
   input logic [WIDTH-1:0]   mplier,
   input logic [2*WIDTH-1:0] product,
   input logic               done,
   input logic               busy
);

   localparam int LW = $clog2(STEPS + 2) + 1;

   logic [2*WIDTH-1:0] exp_q;
   logic [LW-1:0]      lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q <= '0;
         lat_q <= '0;
      end else if (start && !busy) begin
         exp_q <= (2*WIDTH)'(mcand) * (2*WIDTH)'(mplier);
         lat_q <= '0;
      end else if (busy) begin
         lat_q <= lat_q + LW'(1);
      end
   end

   p_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> product == exp_q);

   p_latency_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> int'(lat_q) == STEPS);

   p_busy_done_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (int'(lat_q) + 1 < STEPS)) |=> (busy && lat_q == $past(lat_q) + LW'(1)));

   p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(product)));

   p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done));

endmodule

bind shift_add_mul mul_checker #(.WIDTH(WIDTH), .STEPS(STEPS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .mcand   (mcand),
   .mplier  (mplier),
   .product (product),
   .done    (done),
   .busy    (busy)
);

// File: tb/shift_add_mul_bench.sv
module shift_add_mul_bench;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 4;
   localparam int WATCHDOG   = 100000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [W-1:0]   mcand = '0;
   logic [W-1:0]   mplier = '0;
   logic [2*W-1:0] prod_f;
   logic [2*W-1:0] prod_s;
   logic           done_f;
   logic           done_s;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shift_add_mul #(.WIDTH(W), .STEP_MODE(mul_pkg::STEP_FUSED)) u_shift_add_mul (
      .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
      .product(prod_f), .done(done_f)
   );

   shift_add_mul #(.WIDTH(W), .STEP_MODE(mul_pkg::STEP_SPLIT)) u_shift_add_mul_split (
      .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
      .product(prod_s), .done(done_s)
   );

   task automatic chk(input bit ok, input string req, input int actual, input int expected);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // One multiply on both instances; optional second start pulse mid-run.
   task automatic run_op(input int a, input int b, input bit inject);
      int lat_f = 0;
      int lat_s = 0;
      string rq = inject ? "R5" : "R2";
      @(negedge clk);
      start = 1'b1; mcand = W'(a); mplier = W'(b);
      @(negedge clk);
      start = 1'b0;
      // R7: accepted start clears done on the accepting edge
      chk(!done_f && !done_s, "R7", int'(done_f) + int'(done_s), 0);
      for (int i = 1; i <= 2*W + 2; i++) begin
         if (inject && i == 2) begin
            start = 1'b1; mcand = W'(~a); mplier = W'(b + 5);
         end
         if (inject && i == 3) start = 1'b0;
         @(negedge clk);
         if (done_f && lat_f == 0) lat_f = i;
         if (done_s && lat_s == 0) lat_s = i;
      end
      chk(lat_f == W,     inject ? "R5" : "R3", lat_f, W);
      chk(lat_s == 2 * W, inject ? "R5" : "R4", lat_s, 2 * W);
      chk(int'(prod_f) == a * b, rq, int'(prod_f), a * b);
      chk(int'(prod_s) == a * b, rq, int'(prod_s), a * b);
      // R6: fused done has been up for W+2 cycles and is still held
      chk(done_f == 1'b1, "R6", int'(done_f), 1);
   endtask

   initial begin
      int exp_seq [4] = '{8'h65, 8'h92, 8'h49, 8'h84};
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(prod_f == '0 && prod_s == '0, "R1", int'(prod_f) + int'(prod_s), 0);
      chk(!done_f && !done_s, "R1", int'(done_f) + int'(done_s), 0);
      rst_n = 1'b1;

      // R8: register chain walk, 12 * 11 in fused mode
      @(negedge clk);
      start = 1'b1; mcand = 4'd12; mplier = 4'd11;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(int'(prod_f) == exp_seq[k], "R8", int'(prod_f), exp_seq[k]);
      end
      repeat (W + 2) @(negedge clk);
      // R6: product stays put while done holds
      chk(int'(prod_f) == 132 && done_f, "R6", int'(prod_f), 132);

      // R2/R3/R4/R7: every operand pair
      for (int a = 0; a < (1 << W); a++)
         for (int b = 0; b < (1 << W); b++)
            run_op(a, b, 1'b0);

      // R5: start pulses during a run are ignored
      run_op(13, 11, 1'b1);
      run_op(15, 15, 1'b1);
      run_op(6, 13, 1'b1);

      finish_run();
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            chk(1'b0, "watchdog", cycles, WATCHDOG);
            finish_run();
         end
      end
   end

endmodule